// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the combinational arithmetic-logic unit of a small RISC core. It takes two 8-bit operands, the present carry and zero flags, and a 5-bit operation code. In the same cycle it returns the 8-bit result, a 6-bit vector of new flag values and a 6-bit update mask. The core's status register loads a flag only where the mask bit is 1.

The operations are add and subtract, each with and without carry, and negate. There are also AND, OR, XOR, one's complement, increment and decrement. The shifts are logical left, logical right and arithmetic right, plus rotate left and rotate right through carry, and a swap of the two nibbles. Each operation updates its own set of flags. Subtract-with-carry chains the zero flag, so that a compare of several bytes ends with the correct equal result. The unit has no clock and no state. It has no handshake: a new operation can be applied on every cycle, and the result is valid once the inputs settle.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 is add and opcode 1 is add-with-carry. The result is (a + b [+ carry_in]) mod 256. C is the carry out of bit 7. H is the carry out of bit 3. V is set when two operands of the same sign give a result of the other sign. The mask is 0x3F.
- R2: Opcode 2 is subtract and opcode 3 is subtract-with-carry. The result is (a - b [- carry_in]) mod 256. C is set on a borrow out of bit 7. H is set on a borrow into bit 4. V is the signed overflow of the subtraction. Opcode 4 is negate and gives (0 - a) mod 256, with C = (a != 0), H = (a[3:0] != 0) and V = (a == 0x80). For all three the mask is 0x3F.
- R3: For opcode 3, Z is 1 only when the result is zero and zero_in is 1. A nonzero result clears Z, and a zero result keeps zero_in.
- R4: Opcodes 8, 9 and 10 are AND, OR and XOR. They always clear V, output C as carry_in, and give the mask 0x1E (Z, N, V and S).
- R5: Opcode 11 is one's complement. It returns 0xFF - a, sets C to 1, clears V, and gives the mask 0x1F.
- R6: Opcode 5 is increment and opcode 6 is decrement. They return a+1 or a-1 mod 256 and give the mask 0x1E, with C output as carry_in. Increment sets V only for a = 0x7F. Decrement sets V only for a = 0x80.
- R7: Opcode 16 shifts left with a 0 into bit 0. Opcode 17 shifts right with a 0 into bit 7. Opcode 18 shifts right and keeps bit 7. C takes the bit shifted out, V = N xor C, and the mask is 0x1F.
- R8: Opcode 19 rotates left: carry_in enters bit 0 and bit 7 goes to C. Opcode 20 rotates right: carry_in enters bit 7 and bit 0 goes to C. V = N xor C, and the mask is 0x1F.
- R9: Opcode 21 exchanges bits 7..4 with bits 3..0. Its mask is 0, and it outputs C as carry_in and Z as zero_in.
- R10: Whenever the S mask bit is 1, S equals N xor V. Where N is updated it equals result bit 7. Where Z is updated by any opcode other than 3, it equals (result == 0).
- R11: The flag vector is packed as bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S and bit 5 H. A flag outside the mask outputs carry_in for C, zero_in for Z, and 0 for the others. An unused opcode (7, 12-15, 22-31) returns a unchanged with mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (the only operand of unary operations) |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag, used for chaining |
| opcode | input | 5 | Operation code |
| result | output | 8 | Operation result |
| flags_out | output | 6 | New flag values {H,S,V,N,Z,C} |
| flags_upd | output | 6 | Per-flag update mask, same layout |

## Verification
The hardest cases to reach are the corners where flags interact. One is subtract-with-carry producing zero while zero_in is clear, which must not set Z. The others are the half-borrow and overflow edges, which need exact operand pairs around 0x80 and nibble boundaries. The bench drives every pair of operands for each two-operand opcode, with both carry values. For subtract-with-carry it also uses both zero_in values, so every chaining corner and half-carry corner appears in the stimulus. An arithmetic model in the bench then predicts each output.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int FLAG_W = 6;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;

  localparam logic [FLAG_W-1:0] UPD_ALL   = 6'b111111;
  localparam logic [FLAG_W-1:0] UPD_ZNVS  = 6'b011110;
  localparam logic [FLAG_W-1:0] UPD_ZCNVS = 6'b011111;

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBC  = 5'd3;
  localparam logic [4:0] OP_NEG  = 5'd4;
  localparam logic [4:0] OP_INC  = 5'd5;
  localparam logic [4:0] OP_DEC  = 5'd6;
  localparam logic [4:0] OP_AND  = 5'd8;
  localparam logic [4:0] OP_OR   = 5'd9;
  localparam logic [4:0] OP_XOR  = 5'd10;
  localparam logic [4:0] OP_COM  = 5'd11;
  localparam logic [4:0] OP_LSL  = 5'd16;
  localparam logic [4:0] OP_LSR  = 5'd17;
  localparam logic [4:0] OP_ASR  = 5'd18;
  localparam logic [4:0] OP_ROL  = 5'd19;
  localparam logic [4:0] OP_ROR  = 5'd20;
  localparam logic [4:0] OP_SWAP = 5'd21;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             h_out,
  output logic             v_out
);
  localparam int HB  = WIDTH / 2;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_eff;
  logic             c_eff;
  logic [WIDTH:0]   full;
  logic [HB:0]      low;

  always_comb begin
    y_eff = sub ? ~y : y;
    c_eff = cin ^ sub;
    full  = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, c_eff};
    low   = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
    sum   = full[WIDTH-1:0];
    // a subtraction reports a borrow, which is the inverted carry
    c_out = full[WIDTH] ^ sub;
    h_out = low[HB] ^ sub;
    v_out = (x[MSB] == y_eff[MSB]) && (full[MSB] != x[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (sel)
        2'd0:    out[i] = x[i] & y[i];
        2'd1:    out[i] = x[i] | y[i];
        2'd2:    out[i] = x[i] ^ y[i];
        default: out[i] = ~x[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic             cin,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] out,
  output logic             c_out
);
  localparam int HB  = WIDTH / 2;
  localparam int MSB = WIDTH - 1;

  always_comb begin
    out   = x;
    c_out = cin;
    case (sel)
      3'd0: begin out = {x[MSB-1:0], 1'b0};   c_out = x[MSB]; end
      3'd1: begin out = {1'b0, x[MSB:1]};     c_out = x[0];   end
      3'd2: begin out = {x[MSB], x[MSB:1]};   c_out = x[0];   end
      3'd3: begin out = {x[MSB-1:0], cin};    c_out = x[MSB]; end
      3'd4: begin out = {cin, x[MSB:1]};      c_out = x[0];   end
      3'd5: out = {x[HB-1:0], x[MSB:HB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic [4:0]        opcode,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flags_out,
  output logic [FLAG_W-1:0] flags_upd
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] as_x, as_y, as_sum, lg_out, sh_out;
  logic             as_cin, as_sub, as_c, as_h, as_v, sh_c;
  logic             fc, fz, fn, fv, fs, fh;

  // operand steering for the shared adder
  always_comb begin
    as_x   = op_a;
    as_y   = op_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (opcode)
      OP_ADC: as_cin = carry_in;
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = carry_in; end
      OP_NEG: begin as_x = '0; as_y = op_a; as_sub = 1'b1; end
      OP_INC: begin as_y = '0; as_cin = 1'b1; end
      OP_DEC: begin as_y = '0; as_cin = 1'b1; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .x(op_a), .y(op_b), .sel(opcode[1:0]), .out(lg_out)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .x(op_a), .cin(carry_in), .sel(opcode[2:0]), .out(sh_out), .c_out(sh_c)
  );

  always_comb begin
    result    = op_a;
    fc        = carry_in;
    fv        = 1'b0;
    fh        = 1'b0;
    flags_upd = '0;
    case (opcode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        result = as_sum; fc = as_c; fh = as_h; fv = as_v; flags_upd = UPD_ALL;
      end
      OP_INC, OP_DEC: begin
        result = as_sum; fv = as_v; flags_upd = UPD_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = lg_out; flags_upd = UPD_ZNVS;
      end
      OP_COM: begin
        result = lg_out; fc = 1'b1; flags_upd = UPD_ZCNVS;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        result = sh_out; fc = sh_c; fv = sh_out[MSB] ^ sh_c; flags_upd = UPD_ZCNVS;
      end
      OP_SWAP: result = sh_out;
      default: ;
    endcase
    fn = flags_upd[FLG_N] & result[MSB];
    // chained compare: a zero byte keeps the earlier zero state
    fz = flags_upd[FLG_Z] ? ((result == '0) & ((opcode != OP_SBC) | zero_in)) : zero_in;
    fs = flags_upd[FLG_S] & (fn ^ fv);
    flags_out = {fh, fs, fv, fn, fz, fc};
  end
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]  op_a,
  input logic              carry_in,
  input logic              zero_in,
  input logic [4:0]        opcode,
  input logic [WIDTH-1:0]  result,
  input logic [FLAG_W-1:0] flags_out,
  input logic [FLAG_W-1:0] flags_upd
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (flags_upd[FLG_S])
      AST_SIGN_IS_N_XOR_V: assert (flags_out[FLG_S] == (flags_out[FLG_N] ^ flags_out[FLG_V])) else $error("S mismatch"); // R10
    if (flags_upd[FLG_N])
      AST_N_IS_MSB: assert (flags_out[FLG_N] == result[MSB]) else $error("N mismatch"); // R10
    if (opcode == OP_SBC && !zero_in)
      AST_SBC_Z_CHAIN: assert (!flags_out[FLG_Z]) else $error("Z chain broken"); // R3
    if (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
      AST_LOGIC_KEEPS_CARRY: assert (!flags_upd[FLG_C] && flags_out[FLG_C] == carry_in && !flags_out[FLG_V]) else $error("logic flags"); // R4
    if (opcode == OP_COM)
      AST_COM_SETS_CARRY: assert (flags_out[FLG_C] && !flags_out[FLG_V]) else $error("com flags"); // R5
    if (opcode == OP_SWAP)
      AST_SWAP_NO_FLAGS: assert (flags_upd == '0) else $error("swap mask"); // R9
    if (!flags_upd[FLG_C])
      AST_C_PASSTHROUGH: assert (flags_out[FLG_C] == carry_in) else $error("C passthrough"); // R11
    if (flags_upd == '0)
      AST_Z_PASSTHROUGH: assert (flags_out[FLG_Z] == zero_in) else $error("Z passthrough"); // R11
    if (opcode == 5'd7 || opcode[4:3] == 2'b11)
      AST_UNUSED_IDLE: assert (result == op_a && flags_upd == '0) else $error("unused op"); // R11
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .carry_in(carry_in), .zero_in(zero_in), .opcode(opcode),
  .result(result), .flags_out(flags_out), .flags_upd(flags_upd)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
  logic       clk = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic       carry_in = 1'b0, zero_in = 1'b0;
  logic [4:0] opcode = '0;
  logic [7:0] result;
  logic [5:0] flags_out, flags_upd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_core u_alu8_core (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .zero_in(zero_in),
    .opcode(opcode), .result(result), .flags_out(flags_out), .flags_upd(flags_upd)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // arithmetic model: flags packed {H,S,V,N,Z,C}
  function automatic void model(input int op, input int a, input int b, input int c, input int z,
                                output int r, output logic [5:0] f, output logic [5:0] m);
    int t, ci;
    logic cc, zz, nn, vv, hh, ss;
    r = a; cc = c[0]; vv = 0; hh = 0; m = 6'b0;
    ci = (op == 1 || op == 3) ? c : 0;
    case (op)
      0, 1: begin
        t = a + b + ci; r = t & 255; cc = t > 255;
        hh = ((a & 15) + (b & 15) + ci) > 15;
        t = sgn(a) + sgn(b) + ci; vv = (t > 127) || (t < -128); m = 6'h3F;
      end
      2, 3: begin
        t = a - b - ci; r = t & 255; cc = t < 0;
        hh = ((a & 15) - (b & 15) - ci) < 0;
        t = sgn(a) - sgn(b) - ci; vv = (t > 127) || (t < -128); m = 6'h3F;
      end
      4: begin r = (256 - a) & 255; cc = a != 0; hh = (a & 15) != 0; vv = a == 128; m = 6'h3F; end
      5: begin r = (a + 1) & 255; vv = a == 127; m = 6'h1E; end
      6: begin r = (a + 255) & 255; vv = a == 128; m = 6'h1E; end
      8: begin r = a & b; m = 6'h1E; end
      9: begin r = a | b; m = 6'h1E; end
      10: begin r = a ^ b; m = 6'h1E; end
      11: begin r = 255 - a; cc = 1; m = 6'h1F; end
      16: begin r = (a * 2) & 255; cc = a >= 128; m = 6'h1F; end
      17: begin r = a / 2; cc = (a & 1) != 0; m = 6'h1F; end
      18: begin r = a / 2 + (a & 128); cc = (a & 1) != 0; m = 6'h1F; end
      19: begin r = ((a * 2) & 255) + c; cc = a >= 128; m = 6'h1F; end
      20: begin r = a / 2 + c * 128; cc = (a & 1) != 0; m = 6'h1F; end
      21: begin r = (a & 15) * 16 + a / 16; m = 6'h00; end
      default: ;
    endcase
    nn = m[2] ? (r >= 128) : 1'b0;
    if (op >= 16 && op <= 20) vv = nn ^ cc;
    zz = m[1] ? ((r == 0) && (op != 3 || z != 0)) : z[0];
    ss = m[4] ? (nn ^ vv) : 1'b0;
    f = {hh, ss, vv, nn, zz, cc};
  endfunction

  task automatic check(input int op, input int a, input int b, input int c, input int z, input string tag);
    int er;
    logic [5:0] ef, em;
    model(op, a, b, c, z, er, ef, em);
    opcode = op[4:0]; op_a = a[7:0]; op_b = b[7:0]; carry_in = c[0]; zero_in = z[0];
    #0.5;
    checks++;
    if (result !== er[7:0] || flags_out !== ef || flags_upd !== em) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d z=%0d: got res=%02h f=%06b m=%06b exp res=%02h f=%06b m=%06b",
               tag, op, a, b, c, z, result, flags_out, flags_upd, er[7:0], ef, em);
    end
    if (flags_upd[4]) begin
      checks++;
      if (flags_out[4] !== (flags_out[2] ^ flags_out[3])) begin
        failures++;
        $display("FAIL R10 op=%0d a=%02h: got S=%0b exp %0b", op, a, flags_out[4], flags_out[2] ^ flags_out[3]);
      end
    end
    #0.5;
  endtask

  initial begin
    #1;
    check(0, 0, 0, 0, 0, "R11 initial all-zero add");
    // two-operand opcodes, every operand pair and carry
    for (int op = 0; op <= 10; op++) begin
      if (op == 0 || op == 1 || op == 2 || op == 3 || op == 8 || op == 9 || op == 10) begin
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++) begin
              if (op == 3) begin
                check(op, a, b, c, 0, "R2/R3 sbc z=0");
                check(op, a, b, c, 1, "R2/R3 sbc z=1");
              end else if (op <= 2) check(op, a, b, c, (a ^ b) & 1, "R1/R2 add-sub");
              else check(op, a, b, c, (a + b) & 1, "R4 logic");
            end
      end
    end
    // one-operand opcodes
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 2; c++)
        for (int z = 0; z < 2; z++) begin
          check(4, a, 0, c, z, "R2 neg");
          check(5, a, 0, c, z, "R6 inc");
          check(6, a, 0, c, z, "R6 dec");
          check(11, a, 0, c, z, "R5 com");
          check(16, a, 0, c, z, "R7 lsl");
          check(17, a, 0, c, z, "R7 lsr");
          check(18, a, 0, c, z, "R7 asr");
          check(19, a, 0, c, z, "R8 rol");
          check(20, a, 0, c, z, "R8 ror");
          check(21, a, 0, c, z, "R9 swap");
        end
    // unused codes leave operand and flags alone
    for (int op = 0; op < 32; op++)
      if (op == 7 || (op >= 12 && op <= 15) || op >= 22) begin
        check(op, 8'hA5, 8'h3C, 1, 1, "R11 unused");
        check(op, 8'h00, 8'hFF, 0, 0, "R11 unused");
      end
    // named corners
    check(5, 8'h7F, 0, 0, 0, "R6 inc 7F->80 sets V");
    check(6, 8'h80, 0, 1, 1, "R6 dec 80->7F sets V");
    check(3, 8'h10, 8'h10, 0, 0, "R3 zero result with zero_in clear");
    check(3, 8'h10, 8'h0F, 1, 1, "R3 zero result with zero_in set");
    check(2, 8'h10, 8'h01, 0, 0, "R2 half borrow");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule